// File: doc/BRIEF.md
# Cascadable Display Column Data Latch

This block is the digital front end of a column driver for a thin-film display panel. On every clock it accepts six 6-bit gray codes (two RGB pixels) that arrive on two input ports of three dots each. A start pulse opens a line. The codes of the following clocks are then written into a line register, starting from one end of the column range. A direction input selects which end is filled first. It also selects which start pin the block listens to and which pin carries the cascade pulse to the next device.

When the line register is full, a falling edge on the strobe input copies it into an output hold register. At the same edge the block samples a polarity input. Each output position then carries its 6-bit code and a polarity flag, and the flags alternate between odd and even positions. Each input port has its own inversion control, which complements that port's codes before they are stored. A chain of identical blocks shares one data bus. Each block hands the start pulse on, so the next block takes the clock that directly follows its neighbour's last load.

Top module: `col_latch_top`

## Requirements
- R1: After reset, every code in `line_o` is 0, `pol_o` bit p equals p[0] (odd positions 1, even positions 0), and both carry outputs are 0.
- R2: A high on the active start pin at a rising clock edge opens a line. That edge stores no data. Each of the next OUTPUTS/6 rising edges stores one group of six codes, group k being the k-th such edge.
- R3: With `dir_right_i`=1 the active start pin is `start_r_i`. Dot j (0..5) of group k goes to position 6k+j. Dots 0..2 are `data_a_i[6j+5:6j]` and dots 3..5 are `data_b_i[6(j-3)+5:6(j-3)]`.
- R4: With `dir_right_i`=0 the active start pin is `start_l_i`. Dot j of group k goes to position OUTPUTS-1-(6k+j).
- R5: While `inv_a_i` is 1, the dots from port A are stored bitwise inverted. `inv_b_i` does the same for port B, and each control is independent of the other.
- R6: The cascade pulse is high for exactly the one cycle whose closing rising edge stores the last group. It appears on `carry_l_o` when `dir_right_i`=1 and on `carry_r_o` when `dir_right_i`=0. The two carry outputs are never high together.
- R7: After the last group is stored, data is ignored until the active start pin is high again. A pulse on the inactive start pin opens no line.
- R8: A start on the active pin while a line is open restarts loading at group 0. That edge stores no data and gives no carry pulse.
- R9: The hold register (`line_o`) takes the line register's contents at the rising edge where `strobe_i` is sampled 0 after having been sampled 1 at the edge before. At no other edge do `line_o` or `pol_o` change.
- R10: At that strobe edge `pol_i` is captured. Afterwards `pol_o[p]` = captured value XOR p[0], so with a captured 1 the even positions are the positive ones. Changes of `pol_i` at other times have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Data clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_right_i | input | 1 | 1: fill from position 0, start on right pin; 0: fill from top position, start on left pin |
| start_r_i | input | 1 | Right start pin, active when dir_right_i=1 |
| start_l_i | input | 1 | Left start pin, active when dir_right_i=0 |
| carry_r_o | output | 1 | Right cascade pulse, used when dir_right_i=0 |
| carry_l_o | output | 1 | Left cascade pulse, used when dir_right_i=1 |
| data_a_i | input | 18 | Port A, dots 0..2, 6 bits each |
| data_b_i | input | 18 | Port B, dots 3..5, 6 bits each |
| inv_a_i | input | 1 | Invert port A codes before storage |
| inv_b_i | input | 1 | Invert port B codes before storage |
| strobe_i | input | 1 | Line transfer strobe, falling edge acts |
| pol_i | input | 1 | Polarity select captured at strobe fall |
| line_o | output | OUTPUTS*6 | Hold register, position p at bits [6p+5:6p] |
| pol_o | output | OUTPUTS | Polarity flag per position, 1 = positive |

## Verification
The cascade pulse is a registered-state output. It is due in the cycle that follows the edge that stored the next-to-last group, so the bench checks it before driving each group. The line register updates at the edge that samples a group, but it can only be seen through the hold register. `line_o` and `pol_o` move one edge after `strobe_i` is first driven low. The bench therefore checks them while the strobe is high, before the transfer, and once more after the transfer. By then `pol_i` has already been flipped, so the second check also shows that the flip has no effect. All inputs are driven on the falling clock edge and all outputs are sampled there, which puts every expected value exactly one rising edge after the stimulus that causes it.

// File: rtl/col_latch_pkg.sv
package col_latch_pkg;
  localparam int unsigned NUM_PORTS = 2;

  // position a dot lands on, for both fill orders
  function automatic int unsigned dot_pos(input bit right, input int unsigned grp,
                                          input int unsigned dot, input int unsigned dots,
                                          input int unsigned outputs);
    int unsigned lin;
    lin = grp * dots + dot;
    return right ? lin : (outputs - 1 - lin);
  endfunction
endpackage

// File: rtl/col_load_ctrl.sv
module col_load_ctrl #(
  parameter int unsigned LOADS = 70,
  localparam int unsigned GW = (LOADS > 1) ? $clog2(LOADS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dir_right_i,
  input  logic          start_r_i,
  input  logic          start_l_i,
  output logic          load_o,
  output logic [GW-1:0] grp_o,
  output logic          carry_r_o,
  output logic          carry_l_o
);
  localparam logic [GW-1:0] LAST = GW'(LOADS - 1);

  logic          active_q;
  logic [GW-1:0] cnt_q;
  logic          start_act;
  logic          carry_fire;

  assign start_act  = dir_right_i ? start_r_i : start_l_i;
  assign load_o     = active_q & ~start_act;
  assign grp_o      = cnt_q;
  assign carry_fire = active_q & (cnt_q == LAST);
  assign carry_l_o  = carry_fire & dir_right_i;
  assign carry_r_o  = carry_fire & ~dir_right_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start_act) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q) begin
      if (cnt_q == LAST) active_q <= 1'b0;
      else               cnt_q    <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/col_line_reg.sv
module col_line_reg
  import col_latch_pkg::*;
#(
  parameter int unsigned DOT_W   = 6,
  parameter int unsigned DOTS    = 6,
  parameter int unsigned OUTPUTS = 420,
  parameter int unsigned GW      = 7
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       load_i,
  input  logic [GW-1:0]              grp_i,
  input  logic                       dir_right_i,
  input  logic [DOTS*DOT_W-1:0]      dots_i,
  output logic [OUTPUTS*DOT_W-1:0]   line_o
);
  for (genvar p = 0; p < OUTPUTS; p++) begin : g_pos
    localparam int unsigned GR = p / DOTS;
    localparam int unsigned SR = p % DOTS;
    localparam int unsigned GL = (OUTPUTS - 1 - p) / DOTS;
    localparam int unsigned SL = (OUTPUTS - 1 - p) % DOTS;

    logic [DOT_W-1:0] cell_q;
    logic             hit_r, hit_l;

    assign hit_r = load_i &  dir_right_i & (grp_i == GW'(GR));
    assign hit_l = load_i & ~dir_right_i & (grp_i == GW'(GL));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    cell_q <= '0;
      else if (hit_r) cell_q <= dots_i[SR*DOT_W +: DOT_W];
      else if (hit_l) cell_q <= dots_i[SL*DOT_W +: DOT_W];
    end

    assign line_o[p*DOT_W +: DOT_W] = cell_q;
  end
endmodule

// File: rtl/col_hold_reg.sv
module col_hold_reg #(
  parameter int unsigned DOT_W   = 6,
  parameter int unsigned OUTPUTS = 420
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     strobe_i,
  input  logic                     pol_i,
  input  logic [OUTPUTS*DOT_W-1:0] line_i,
  output logic [OUTPUTS*DOT_W-1:0] hold_o,
  output logic [OUTPUTS-1:0]       pol_o
);
  logic strobe_q, pol_q, xfer;
  logic [OUTPUTS*DOT_W-1:0] hold_q;

  assign xfer = strobe_q & ~strobe_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b0;
      pol_q    <= 1'b0;
      hold_q   <= '0;
    end else begin
      strobe_q <= strobe_i;
      if (xfer) begin
        pol_q  <= pol_i;
        hold_q <= line_i;
      end
    end
  end

  assign hold_o = hold_q;

  // odd/even positions carry opposite polarity
  for (genvar p = 0; p < OUTPUTS; p++) begin : g_pol
    if (p % 2 == 1) begin : g_odd
      assign pol_o[p] = ~pol_q;
    end else begin : g_even
      assign pol_o[p] = pol_q;
    end
  end
endmodule

// File: rtl/col_latch_top.sv
module col_latch_top
  import col_latch_pkg::*;
#(
  parameter int unsigned DOT_W         = 6,
  parameter int unsigned DOTS_PER_PORT = 3,
  parameter int unsigned OUTPUTS       = 420,
  localparam int unsigned PORT_W = DOTS_PER_PORT * DOT_W,
  localparam int unsigned LINE_W = OUTPUTS * DOT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_right_i,
  input  logic              start_r_i,
  input  logic              start_l_i,
  output logic              carry_r_o,
  output logic              carry_l_o,
  input  logic [PORT_W-1:0] data_a_i,
  input  logic [PORT_W-1:0] data_b_i,
  input  logic              inv_a_i,
  input  logic              inv_b_i,
  input  logic              strobe_i,
  input  logic              pol_i,
  output logic [LINE_W-1:0] line_o,
  output logic [OUTPUTS-1:0] pol_o
);
  localparam int unsigned DOTS  = NUM_PORTS * DOTS_PER_PORT;
  localparam int unsigned LOADS = OUTPUTS / DOTS;
  localparam int unsigned GW    = (LOADS > 1) ? $clog2(LOADS) : 1;

  logic [DOTS*DOT_W-1:0] dots;
  logic [LINE_W-1:0]     line_raw;
  logic                  load;
  logic [GW-1:0]         grp;

  // per-port inversion ahead of storage
  for (genvar j = 0; j < DOTS_PER_PORT; j++) begin : g_in
    assign dots[j*DOT_W +: DOT_W] =
      data_a_i[j*DOT_W +: DOT_W] ^ {DOT_W{inv_a_i}};
    assign dots[(j+DOTS_PER_PORT)*DOT_W +: DOT_W] =
      data_b_i[j*DOT_W +: DOT_W] ^ {DOT_W{inv_b_i}};
  end

  col_load_ctrl #(.LOADS(LOADS)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dir_right_i (dir_right_i),
    .start_r_i   (start_r_i),
    .start_l_i   (start_l_i),
    .load_o      (load),
    .grp_o       (grp),
    .carry_r_o   (carry_r_o),
    .carry_l_o   (carry_l_o)
  );

  col_line_reg #(.DOT_W(DOT_W), .DOTS(DOTS), .OUTPUTS(OUTPUTS), .GW(GW)) u_line (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .grp_i       (grp),
    .dir_right_i (dir_right_i),
    .dots_i      (dots),
    .line_o      (line_raw)
  );

  col_hold_reg #(.DOT_W(DOT_W), .OUTPUTS(OUTPUTS)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (strobe_i),
    .pol_i    (pol_i),
    .line_i   (line_raw),
    .hold_o   (line_o),
    .pol_o    (pol_o)
  );
endmodule

// File: rtl/col_latch_chk.sv
module col_latch_chk #(
  parameter int unsigned LINE_W  = 2520,
  parameter int unsigned OUTPUTS = 420
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               dir_right_i,
  input logic               start_r_i,
  input logic               start_l_i,
  input logic               strobe_i,
  input logic               carry_r_o,
  input logic               carry_l_o,
  input logic [LINE_W-1:0]  line_o,
  input logic [OUTPUTS-1:0] pol_o
);
  logic strobe_seen_q;
  logic start_act;

  assign start_act = dir_right_i ? start_r_i : start_l_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_seen_q <= 1'b0;
    else         strobe_seen_q <= strobe_i;
  end

  p_carry_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(carry_r_o && carry_l_o));

  p_carry_width_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (carry_r_o || carry_l_o) |=> !(carry_r_o || carry_l_o));

  p_restart_no_carry_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_act |=> !(carry_r_o || carry_l_o));

  p_hold_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(strobe_seen_q && !strobe_i) |=> ($stable(line_o) && $stable(pol_o)));

  p_pol_alt_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pol_o[0] != pol_o[1]);
endmodule

bind col_latch_top col_latch_chk #(.LINE_W(LINE_W), .OUTPUTS(OUTPUTS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dir_right_i (dir_right_i),
  .start_r_i   (start_r_i),
  .start_l_i   (start_l_i),
  .strobe_i    (strobe_i),
  .carry_r_o   (carry_r_o),
  .carry_l_o   (carry_l_o),
  .line_o      (line_o),
  .pol_o       (pol_o)
);

// File: tb/col_latch_top_tb.sv
module col_latch_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW   = 6;
  localparam int DPP  = 3;
  localparam int N    = 24;
  localparam int DOTS = 2 * DPP;
  localparam int LOADS = N / DOTS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir_right = 1'b1, start_r = 1'b0, start_l = 1'b0;
  logic carry_r, carry_l;
  logic [DPP*DW-1:0] data_a = '0, data_b = '0;
  logic inv_a = 1'b0, inv_b = 1'b0, strobe = 1'b0, pol = 1'b0;
  logic [N*DW-1:0] line;
  logic [N-1:0] polv;

  int total = 0, bad = 0;
  logic [DW-1:0] exp_line [N];
  logic [DW-1:0] exp_hold [N];
  bit exp_pol = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  col_latch_top #(.DOT_W(DW), .DOTS_PER_PORT(DPP), .OUTPUTS(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .dir_right_i(dir_right),
    .start_r_i(start_r), .start_l_i(start_l),
    .carry_r_o(carry_r), .carry_l_o(carry_l),
    .data_a_i(data_a), .data_b_i(data_b), .inv_a_i(inv_a), .inv_b_i(inv_b),
    .strobe_i(strobe), .pol_i(pol), .line_o(line), .pol_o(polv)
  );

  function automatic logic [DW-1:0] dv(int seed, int k, int j);
    return DW'((seed * 11 + k * 7 + j * 5 + 3) % 64);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_carry(string req, bit exp_r, bit exp_l);
    check(req, {62'd0, carry_r, carry_l}, {62'd0, exp_r, exp_l});
  endtask

  // compares the whole hold register and polarity vector
  task automatic check_hold(string req);
    int errs = 0;
    int first = -1;
    for (int p = 0; p < N; p++) begin
      if (line[p*DW +: DW] !== exp_hold[p] || polv[p] !== (exp_pol ^ p[0])) begin
        errs++;
        if (first < 0) first = p;
      end
    end
    total++;
    if (errs != 0) begin
      bad++;
      $display("FAIL %s pos=%0d actual=%0h/%0b expected=%0h/%0b", req, first,
               line[first*DW +: DW], polv[first], exp_hold[first], exp_pol ^ first[0]);
    end
  endtask

  // called at a falling edge, returns at a falling edge
  task automatic run_line(bit dir, bit ia, bit ib, int seed, int nload, string req);
    dir_right = dir; inv_a = ia; inv_b = ib;
    if (dir) start_r = 1'b1; else start_l = 1'b1;
    data_a = '1; data_b = '1;   // present on the start edge, must not be stored (R2)
    @(negedge clk);
    start_r = 1'b0; start_l = 1'b0;
    for (int k = 0; k < nload; k++) begin
      bit last = (k == LOADS - 1);
      check_carry({req, " R6 carry"}, last && !dir, last && dir);
      for (int j = 0; j < DOTS; j++) begin
        logic [DW-1:0] v = dv(seed, k, j);
        int pos = dir ? (k * DOTS + j) : (N - 1 - (k * DOTS + j));
        if (j < DPP) begin
          data_a[j*DW +: DW] = v;
          exp_line[pos] = ia ? ~v : v;
        end else begin
          data_b[(j-DPP)*DW +: DW] = v;
          exp_line[pos] = ib ? ~v : v;
        end
      end
      @(negedge clk);
    end
  endtask

  task automatic do_strobe(bit pv, string req);
    strobe = 1'b1;
    @(negedge clk);
    check_hold({req, " R9 before fall"});
    strobe = 1'b0; pol = pv;
    @(negedge clk);
    for (int p = 0; p < N; p++) exp_hold[p] = exp_line[p];
    exp_pol = pv;
    pol = ~pv;                   // late change must not reach pol_o (R10)
    @(negedge clk);
    check_hold({req, " R10 after fall"});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int p = 0; p < N; p++) begin exp_line[p] = '0; exp_hold[p] = '0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    check_hold("R1 reset");
    check_carry("R1 reset carry", 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 right fill, R2 start edge empty
    run_line(1'b1, 1'b0, 1'b0, 1, LOADS, "R3");
    check_carry("R6 after line", 1'b0, 1'b0);
    do_strobe(1'b1, "R3 R2");

    // R4 left fill
    run_line(1'b0, 1'b0, 1'b0, 2, LOADS, "R4");
    check_carry("R6 after left line", 1'b0, 1'b0);
    do_strobe(1'b0, "R4");

    // R5 inversion, every combination in both directions
    for (int c = 0; c < 4; c++) begin
      for (int d = 0; d < 2; d++) begin
        run_line(d[0], c[0], c[1], 3 + c * 2 + d, LOADS, "R5");
        do_strobe(c[0] ^ d[0], "R5");
      end
    end

    // R7 data after last load and inactive start pin are ignored
    run_line(1'b1, 1'b0, 1'b0, 20, LOADS, "R7");
    data_a = '0; data_b = '1; inv_a = 1'b1;
    repeat (3) @(negedge clk);
    start_l = 1'b1;              // inactive while dir_right=1
    @(negedge clk);
    start_l = 1'b0; data_a = 18'h15555;
    check_carry("R7 inactive start carry", 1'b0, 1'b0);
    repeat (LOADS + 1) @(negedge clk);
    check_carry("R7 no line opened", 1'b0, 1'b0);
    do_strobe(1'b1, "R7 ignored data");

    // R8 restart mid-line
    run_line(1'b0, 1'b0, 1'b0, 30, 2, "R8 part");
    check_carry("R8 mid-line no carry", 1'b0, 1'b0);
    run_line(1'b0, 1'b0, 1'b1, 31, LOADS, "R8 restart");
    do_strobe(1'b0, "R8");

    // R9 strobe held high over many cycles: no transfer until it falls
    run_line(1'b1, 1'b1, 1'b0, 40, LOADS, "R9");
    strobe = 1'b1;
    repeat (4) begin
      pol = ~pol;
      @(negedge clk);
      check_hold("R9 strobe high");
    end
    strobe = 1'b0;
    do_strobe(1'b1, "R9 R10");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule